// File: doc/BRIEF.md
# Profiling Record Filter

This block sits between a sampling unit and the logic that stores profiling records. Each cycle it can take one completed sample record. A record holds an operation kind, a 12-bit event field and a total latency. The latency is counted from the moment sampling began on the operation, not from the start of execution alone.

The block decides whether to keep or discard each record. It keeps a record only if the record passes all three programmable tests:

- an operation-kind selection;
- an event mask, every bit of which must be present in the record;
- a latency floor.

Kept records leave through a valid/ready output stage one cycle after they are accepted. Discarded records stop here and add one to a saturating discard counter.

Top module: `prof_rec_filter`

## Requirements
- R1: After reset, `out_valid` is 0 and `discard_count` is 0.
- R2: `in_kind` is encoded as 0 = other, 1 = branch, 2 = load and 3 = store. `cfg_type_en` bit 0 selects branches, bit 1 selects loads and bit 2 selects stores. When `cfg_type_en` is 0, every kind passes. Otherwise a record passes only if its kind is one of the selected kinds, and kind "other" never passes.
- R3: A record passes the event test only when every bit set in `cfg_evt_mask` is also set in `in_events`. A zero mask passes every record. The event bit positions are: bit 1 = retired, bit 3 = L1 data refill, bit 5 = TLB refill, bit 7 = branch mispredict, bit 11 = misaligned access.
- R4: A record passes the latency test only when `in_latency` >= `cfg_min_lat`. A latency equal to the floor passes.
- R5: A record accepted at a clock edge and passing all tests is presented with `out_valid` = 1 after that edge. Its kind, events and latency are carried unchanged.
- R6: A record accepted at a clock edge and failing any test does not raise `out_valid`. It increments `discard_count` by exactly one after that edge.
- R7: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the output record holds stable. No new input is taken while the stall lasts.
- R8: `discard_count` saturates at its maximum value and never wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input record present |
| in_ready | output | 1 | Block can take a record this cycle |
| in_kind | input | 2 | Operation kind of input record |
| in_events | input | EVT_W | Event bits of input record |
| in_latency | input | LAT_W | Total latency of input record |
| cfg_type_en | input | 3 | Kind selection: branch, load, store |
| cfg_evt_mask | input | EVT_W | Required event bits |
| cfg_min_lat | input | LAT_W | Latency floor |
| out_valid | output | 1 | Kept record present |
| out_ready | input | 1 | Downstream accepts the record |
| out_kind | output | 2 | Kind of kept record |
| out_events | output | EVT_W | Events of kept record |
| out_latency | output | LAT_W | Latency of kept record |
| discard_count | output | CNT_W | Saturating count of discarded records |

## Verification
The hardest case to reach is a stall where a new record is already waiting at the input while the held output is refused. The stimulus holds `out_ready` low after a kept record and presents a second, different record for several cycles. It checks that the output stays stable. It then releases `out_ready` and checks that the waiting record replaces the old one on the very next edge. Counter saturation uses a narrow counter width so that a short run of failing records drives the counter to its ceiling and beyond.

// File: rtl/prof_rec_filter.sv
module prof_rec_filter #(
  parameter int EVT_W = 12,
  parameter int LAT_W = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [EVT_W-1:0] in_events,
  input  logic [LAT_W-1:0] in_latency,
  input  logic [2:0]       cfg_type_en,
  input  logic [EVT_W-1:0] cfg_evt_mask,
  input  logic [LAT_W-1:0] cfg_min_lat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [EVT_W-1:0] out_events,
  output logic [LAT_W-1:0] out_latency,
  output logic [CNT_W-1:0] discard_count
);
  localparam logic [1:0] KIND_BR = 2'd1;
  localparam logic [1:0] KIND_LD = 2'd2;
  localparam logic [1:0] KIND_ST = 2'd3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic type_ok, evt_ok, lat_ok, keep, take;

  assign type_ok = (cfg_type_en == 3'b000)
                || (cfg_type_en[0] && in_kind == KIND_BR)
                || (cfg_type_en[1] && in_kind == KIND_LD)
                || (cfg_type_en[2] && in_kind == KIND_ST);
  assign evt_ok  = (in_events & cfg_evt_mask) == cfg_evt_mask;
  assign lat_ok  = in_latency >= cfg_min_lat;
  assign keep    = type_ok && evt_ok && lat_ok;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_kind      <= '0;
      out_events    <= '0;
      out_latency   <= '0;
      discard_count <= '0;
    end else begin
      if (in_ready)
        out_valid <= take && keep;
      if (take && keep) begin
        out_kind    <= in_kind;
        out_events  <= in_events;
        out_latency <= in_latency;
      end
      if (take && !keep && discard_count != CNT_MAX)
        discard_count <= discard_count + 1'b1;
    end
  end
endmodule

// File: rtl/prof_rec_filter_chk.sv
module prof_rec_filter_chk #(
  parameter int EVT_W = 12,
  parameter int LAT_W = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [EVT_W-1:0] cfg_evt_mask,
  input logic [LAT_W-1:0] cfg_min_lat,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [EVT_W-1:0] out_events,
  input logic [LAT_W-1:0] out_latency,
  input logic [CNT_W-1:0] discard_count
);
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_STALL_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind)
                                   && $stable(out_events) && $stable(out_latency))); // R7

  AST_KEPT_MEETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (!out_valid || ((out_events & $past(cfg_evt_mask)) == $past(cfg_evt_mask)))); // R3

  AST_KEPT_MEETS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_valid || out_latency >= $past(cfg_min_lat))); // R4

  AST_COUNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_count != $past(discard_count)) |->
      (discard_count == $past(discard_count) + 1'b1)); // R6

  AST_COUNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (&$past(discard_count)) |-> (&discard_count)); // R8
endmodule

bind prof_rec_filter prof_rec_filter_chk #(
  .EVT_W(EVT_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_evt_mask(cfg_evt_mask), .cfg_min_lat(cfg_min_lat),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_events(out_events), .out_latency(out_latency),
  .discard_count(discard_count)
);

// File: tb/test_prof_rec_filter.sv
module test_prof_rec_filter;
  localparam int EW = 12;
  localparam int LW = 12;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, out_valid, out_ready;
  logic [1:0]    in_kind, out_kind;
  logic [EW-1:0] in_events, out_events, cfg_evt_mask;
  logic [LW-1:0] in_latency, out_latency, cfg_min_lat;
  logic [2:0]    cfg_type_en;
  logic [CW-1:0] discard_count;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  prof_rec_filter #(.EVT_W(EW), .LAT_W(LW), .CNT_W(CW)) i_prof_rec_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_events(in_events), .in_latency(in_latency),
    .cfg_type_en(cfg_type_en), .cfg_evt_mask(cfg_evt_mask),
    .cfg_min_lat(cfg_min_lat), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_events(out_events), .out_latency(out_latency),
    .discard_count(discard_count)
  );

  typedef struct packed {
    logic [1:0]    kind;
    logic [EW-1:0] ev;
    logic [LW-1:0] lat;
    logic [2:0]    ten;
    logic [EW-1:0] mask;
    logic [LW-1:0] minl;
    logic          keep;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 12'h000, 12'd5,    3'b000, 12'h000, 12'd0,    1'b1}, // R2 no type filter
    '{2'd1, 12'h000, 12'd5,    3'b001, 12'h000, 12'd0,    1'b1}, // R2 branch only
    '{2'd2, 12'h000, 12'd5,    3'b001, 12'h000, 12'd0,    1'b0}, // R2 load rejected
    '{2'd3, 12'h000, 12'd5,    3'b110, 12'h000, 12'd0,    1'b1}, // R2 load|store
    '{2'd0, 12'h000, 12'd5,    3'b111, 12'h000, 12'd0,    1'b0}, // R2 other rejected
    '{2'd0, 12'h000, 12'd5,    3'b000, 12'h000, 12'd0,    1'b1}, // R2 other, no filter
    '{2'd2, 12'h082, 12'd5,    3'b000, 12'h080, 12'd0,    1'b1}, // R3 mispredict present
    '{2'd2, 12'h008, 12'd5,    3'b000, 12'h088, 12'd0,    1'b0}, // R3 mispredict missing
    '{2'd3, 12'h8AA, 12'd5,    3'b000, 12'h8AA, 12'd0,    1'b1}, // R3 all five bits
    '{2'd2, 12'h000, 12'd10,   3'b000, 12'h000, 12'd10,   1'b1}, // R4 equal
    '{2'd2, 12'h000, 12'd9,    3'b000, 12'h000, 12'd10,   1'b0}, // R4 below
    '{2'd1, 12'h002, 12'd4095, 3'b001, 12'h002, 12'd4095, 1'b1}, // R4 top value
    '{2'd3, 12'h000, 12'd0,    3'b100, 12'h000, 12'd1,    1'b0}  // R4 zero latency
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_kind = v.kind; in_events = v.ev; in_latency = v.lat;
    cfg_type_en = v.ten; cfg_evt_mask = v.mask; cfg_min_lat = v.minl;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(discard_count == 0, "R1 discard_count", int'(discard_count), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (!VEC[i].keep && exp_cnt < 15) exp_cnt++;
      check(out_valid == VEC[i].keep, $sformatf("R2 R3 R4 R5 R6 vector %0d valid", i),
            int'(out_valid), int'(VEC[i].keep));
      if (VEC[i].keep)
        check(out_kind == VEC[i].kind && out_events == VEC[i].ev && out_latency == VEC[i].lat,
              $sformatf("R5 vector %0d latency", i), int'(out_latency), int'(VEC[i].lat));
      check(int'(discard_count) == exp_cnt, $sformatf("R6 vector %0d count", i),
            int'(discard_count), exp_cnt);
    end

    // R7 stall with a waiting record
    out_ready = 1'b0;
    drive('{2'd2, 12'h00A, 12'd33, 3'b000, 12'h000, 12'd0, 1'b1});
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive('{2'd3, 12'h020, 12'd77, 3'b000, 12'h000, 12'd0, 1'b1});
    for (int k = 0; k < 3; k++) begin
      check(out_valid && !in_ready, "R7 stall valid/ready", int'(in_ready), 0);
      check(out_kind == 2'd2 && out_events == 12'h00A && out_latency == 12'd33,
            "R7 held latency", int'(out_latency), 33);
      @(posedge clk);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_kind == 2'd3 && out_latency == 12'd77,
          "R7 waiting record taken", int'(out_latency), 77);
    check(int'(discard_count) == exp_cnt, "R7 no count change", int'(discard_count), exp_cnt);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R5 output drains", int'(out_valid), 0);

    // R8 saturation
    drive('{2'd0, 12'h000, 12'd0, 3'b001, 12'h000, 12'd0, 1'b0});
    in_valid = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(discard_count == 4'hF, "R8 saturated", int'(discard_count), 15);
    check(out_valid == 1'b0, "R6 no output on discard", int'(out_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule